// File: doc/BRIEF.md
# Capture/Compare Timer Channel with Interrupt Flags

This block is a single channel of an up-counting timer with one capture/compare register. A prescaler scales the counter clock by a power of two. A gate can freeze the counter while the chip is halted for debugging. The counter runs from zero up to a programmable limit and then wraps back to zero. The shared register either holds a compare value that is matched against the counter, or receives a snapshot of the counter when a capture pulse arrives.

Four status flags record these events: compare-or-capture, capture overrun, limit reached and zero reached. Each flag stays set until software writes a one to its bit. Each flag also has an enable bit, and the channel drives a single interrupt request from the enabled flags. Software uses a write port and a read port. Reads are combinational, and a write takes effect at the next clock edge.

Register addresses: 0 control, 1 limit, 2 capture/compare, 3 flags, 4 flag enables, 5 counter.

Top module: `cc_timer_chan`

## Requirements
- R1: With the mode bit (control bit 1) at 0, flag bit 0 sets in the same edge at which the counter steps onto the value held at address 2.
- R2: With control bit 1 at 1, a one-cycle pulse on `cap_trig` copies the counter value from before the edge into address 2 and sets flag bit 0. In this mode compare matches do not occur.
- R3: Flag bit 1 (overrun) sets when a capture lands while flag bit 0 is already 1, and at no other time.
- R4: Flag bit 2 sets when the counter steps onto the limit at address 1. The step after the limit returns the counter to 0.
- R5: Flag bit 3 sets when the counter steps onto 0.
- R6: A flag rises only on its event and stays set until software writes 1 to its bit at address 3. Writing 0 changes nothing. If a set event and a clear meet in the same cycle, the flag stays set.
- R7: `irq` is 1 exactly when some flag is 1 and its bit at address 4 is 1.
- R8: While `dbg_mode` is 1 and control bit 8 is 0, the counter holds its value. With control bit 8 at 1, the counter keeps running.
- R9: Control bits 7:4 hold a value d. While control bit 0 (run) is 1 and the counter is not gated, the counter steps once every 2^d cycles, counting from the cycle run became 1.
- R10: After reset, every register, flag and enable reads 0 and `irq` is 0. A write to address 5 loads the counter, and this load takes priority over a step in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| dbg_mode | input | 1 | High while the system is halted for debugging |
| cap_trig | input | 1 | Synchronous one-cycle capture pulse |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 3 | Write address |
| wr_data | input | 16 | Write data |
| rd_addr | input | 3 | Read address |
| rd_data | output | 16 | Combinational read data |
| irq | output | 1 | Interrupt request |

## Verification
Two things can land on a flag in the same cycle: a hardware set event and a software write-one clear. The bench provokes this by driving `cap_trig` in the same cycle as a write of 1 to flag bit 0 while that flag is already pending. It then expects both flag bit 0 and the overrun bit to read 1. A second collision is a capture while flag bit 0 is pending. The bench judges it by reading back the captured counter value together with the overrun bit.

// File: rtl/tmr_pkg.sv
package tmr_pkg;
  localparam int NFLAG    = 4;
  localparam int F_CMPCAP = 0;
  localparam int F_OVRUN  = 1;
  localparam int F_LIMIT  = 2;
  localparam int F_ZERO   = 3;

  localparam logic [2:0] A_CTRL  = 3'd0;
  localparam logic [2:0] A_LIMIT = 3'd1;
  localparam logic [2:0] A_CCR   = 3'd2;
  localparam logic [2:0] A_FLAGS = 3'd3;
  localparam logic [2:0] A_IEN   = 3'd4;
  localparam logic [2:0] A_COUNT = 3'd5;

  // low "sel" bits set: the prescaler fires when these bits are all ones
  function automatic logic [31:0] div_mask(input int unsigned sel);
    return (32'h1 << sel) - 32'h1;
  endfunction
endpackage

// File: rtl/tmr_prescale.sv
module tmr_prescale #(
  parameter int DIV_W = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             run,
  input  logic             dbg_mode,
  input  logic             dbg_run,
  input  logic [DIV_W-1:0] div,
  output logic             tick
);
  localparam int PC_W = (1 << DIV_W) - 1;

  logic [PC_W-1:0] pc_q;
  logic [PC_W-1:0] mask;
  logic            gate_en;

  assign gate_en = run & (~dbg_mode | dbg_run);
  assign mask    = PC_W'(tmr_pkg::div_mask(int'(div)));
  assign tick    = gate_en && ((pc_q & mask) == mask);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       pc_q <= '0;
    else if (!run)    pc_q <= '0;
    else if (gate_en) pc_q <= pc_q + 1'b1;
  end

  // R8: while gated off, the prescaler state does not move
  assert_gate_holds_R8: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(run) && !$past(gate_en)) |-> pc_q == $past(pc_q));
endmodule

// File: rtl/tmr_counter.sv
module tmr_counter #(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             tick,
  input  logic             load,
  input  logic [CNT_W-1:0] load_val,
  input  logic [CNT_W-1:0] limit,
  input  logic [CNT_W-1:0] cmp_val,
  input  logic             cmp_mode,
  output logic [CNT_W-1:0] cnt,
  output logic             ev_limit,
  output logic             ev_zero,
  output logic             ev_match
);
  logic [CNT_W-1:0] cnt_q;
  logic [CNT_W-1:0] cnt_nxt;
  logic             step;

  function automatic logic [CNT_W-1:0] next_count(input logic [CNT_W-1:0] c,
                                                  input logic [CNT_W-1:0] m);
    return (c == m) ? '0 : c + 1'b1;
  endfunction

  assign cnt_nxt  = next_count(cnt_q, limit);
  assign step     = tick & ~load;
  assign ev_limit = step && (cnt_nxt == limit);
  assign ev_zero  = step && (cnt_nxt == '0);
  assign ev_match = step && cmp_mode && (cnt_nxt == cmp_val);
  assign cnt      = cnt_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    cnt_q <= '0;
    else if (load) cnt_q <= load_val;
    else if (step) cnt_q <= cnt_nxt;
  end

  // R4: stepping from the limit always lands on zero
  assert_wrap_R4: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(tick) && !$past(load) && $past(cnt_q) == $past(limit)) |-> cnt_q == '0);
  // R9: no step, no load -> counter unchanged
  assert_hold_no_tick_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (!$past(tick) && !$past(load)) |-> cnt_q == $past(cnt_q));
endmodule

// File: rtl/tmr_flags.sv
module tmr_flags #(
  parameter int NF = 4
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [NF-1:0] set_ev,
  input  logic [NF-1:0] clr,
  input  logic          ien_we,
  input  logic [NF-1:0] ien_wd,
  output logic [NF-1:0] flags,
  output logic [NF-1:0] ien,
  output logic          irq
);
  logic [NF-1:0] flags_q;
  logic [NF-1:0] ien_q;

  for (genvar i = 0; i < NF; i++) begin : g_flag
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) flags_q[i] <= 1'b0;
      else        flags_q[i] <= (flags_q[i] & ~clr[i]) | set_ev[i];
    end

    // R6: a flag only rises on its own event
    assert_rise_has_cause_R6: assert property (@(posedge clk) disable iff (!rst_n)
      (flags_q[i] && !$past(flags_q[i])) |-> $past(set_ev[i]));
    // R6: a flag only falls on a write-one clear without a competing set
    assert_fall_on_clear_R6: assert property (@(posedge clk) disable iff (!rst_n)
      (!flags_q[i] && $past(flags_q[i])) |-> ($past(clr[i]) && !$past(set_ev[i])));
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      ien_q <= '0;
    else if (ien_we) ien_q <= ien_wd;
  end

  assign flags = flags_q;
  assign ien   = ien_q;
  assign irq   = |(flags_q & ien_q);

  // R3: overrun can only appear while the capture flag was pending
  assert_ovrun_needs_pending_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (flags_q[tmr_pkg::F_OVRUN] && !$past(flags_q[tmr_pkg::F_OVRUN]))
      |-> $past(flags_q[tmr_pkg::F_CMPCAP]));
endmodule

// File: rtl/cc_timer_chan.sv
module cc_timer_chan #(
  parameter int CNT_W = 16,
  parameter int DIV_W = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             dbg_mode,
  input  logic             cap_trig,
  input  logic             wr_en,
  input  logic [2:0]       wr_addr,
  input  logic [CNT_W-1:0] wr_data,
  input  logic [2:0]       rd_addr,
  output logic [CNT_W-1:0] rd_data,
  output logic             irq
);
  import tmr_pkg::*;

  localparam int B_RUN  = 0;
  localparam int B_MODE = 1;
  localparam int B_DIV  = 4;
  localparam int B_DBG  = 8;

  logic             run_q, cap_mode_q, dbg_run_q;
  logic [DIV_W-1:0] div_q;
  logic [CNT_W-1:0] limit_q, ccr_q, cnt;
  logic             tick, cnt_ld, cap_ev;
  logic             ev_limit, ev_zero, ev_match;
  logic [NFLAG-1:0] set_ev, clr, flags, ien;
  logic             wr_ctrl, wr_limit, wr_ccr, wr_flags, wr_ien;

  assign wr_ctrl  = wr_en && (wr_addr == A_CTRL);
  assign wr_limit = wr_en && (wr_addr == A_LIMIT);
  assign wr_ccr   = wr_en && (wr_addr == A_CCR);
  assign wr_flags = wr_en && (wr_addr == A_FLAGS);
  assign wr_ien   = wr_en && (wr_addr == A_IEN);
  assign cnt_ld   = wr_en && (wr_addr == A_COUNT);
  assign cap_ev   = cap_trig & cap_mode_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      run_q      <= 1'b0;
      cap_mode_q <= 1'b0;
      dbg_run_q  <= 1'b0;
      div_q      <= '0;
      limit_q    <= '0;
      ccr_q      <= '0;
    end else begin
      if (wr_ctrl) begin
        run_q      <= wr_data[B_RUN];
        cap_mode_q <= wr_data[B_MODE];
        div_q      <= wr_data[B_DIV +: DIV_W];
        dbg_run_q  <= wr_data[B_DBG];
      end
      if (wr_limit) limit_q <= wr_data;
      if (cap_ev)      ccr_q <= cnt;
      else if (wr_ccr) ccr_q <= wr_data;
    end
  end

  tmr_prescale #(.DIV_W(DIV_W)) u_pre (
    .clk(clk), .rst_n(rst_n), .run(run_q), .dbg_mode(dbg_mode),
    .dbg_run(dbg_run_q), .div(div_q), .tick(tick)
  );

  tmr_counter #(.CNT_W(CNT_W)) u_cnt (
    .clk(clk), .rst_n(rst_n), .tick(tick), .load(cnt_ld), .load_val(wr_data),
    .limit(limit_q), .cmp_val(ccr_q), .cmp_mode(~cap_mode_q), .cnt(cnt),
    .ev_limit(ev_limit), .ev_zero(ev_zero), .ev_match(ev_match)
  );

  always_comb begin
    set_ev           = '0;
    set_ev[F_CMPCAP] = ev_match | cap_ev;
    set_ev[F_OVRUN]  = cap_ev & flags[F_CMPCAP];
    set_ev[F_LIMIT]  = ev_limit;
    set_ev[F_ZERO]   = ev_zero;
    clr              = wr_flags ? wr_data[NFLAG-1:0] : '0;
  end

  tmr_flags #(.NF(NFLAG)) u_flg (
    .clk(clk), .rst_n(rst_n), .set_ev(set_ev), .clr(clr), .ien_we(wr_ien),
    .ien_wd(wr_data[NFLAG-1:0]), .flags(flags), .ien(ien), .irq(irq)
  );

  always_comb begin
    rd_data = '0;
    case (rd_addr)
      A_CTRL: begin
        rd_data[B_RUN]          = run_q;
        rd_data[B_MODE]         = cap_mode_q;
        rd_data[B_DIV +: DIV_W] = div_q;
        rd_data[B_DBG]          = dbg_run_q;
      end
      A_LIMIT: rd_data = limit_q;
      A_CCR:   rd_data = ccr_q;
      A_FLAGS: rd_data[NFLAG-1:0] = flags;
      A_IEN:   rd_data[NFLAG-1:0] = ien;
      A_COUNT: rd_data = cnt;
      default: rd_data = '0;
    endcase
  end

  // R2: a capture stores the counter value seen at the capture edge
  assert_capture_value_R2: assert property (@(posedge clk) disable iff (!rst_n)
    $past(cap_ev) |-> ccr_q == $past(cnt));
  // R8: gated in debug -> counter frozen unless software loads it
  assert_debug_freeze_R8: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(dbg_mode) && !$past(dbg_run_q) && !$past(cnt_ld)) |-> cnt == $past(cnt));
endmodule

// File: tb/sim_cc_timer_chan.sv
`timescale 1ns/1ps
module sim_cc_timer_chan;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        dbg_mode = 1'b0, cap_trig = 1'b0, wr_en = 1'b0;
  logic [2:0]  wr_addr = '0, rd_addr = '0;
  logic [15:0] wr_data = '0;
  logic [15:0] rd_data;
  logic        irq;
  int          total = 0, bad = 0;

  always #4 clk = ~clk;

  cc_timer_chan u0 (
    .clk(clk), .rst_n(rst_n), .dbg_mode(dbg_mode), .cap_trig(cap_trig),
    .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .rd_addr(rd_addr), .rd_data(rd_data), .irq(irq)
  );

  // {limit, cmp, div, cycles, exp_count, exp_flags}
  localparam logic [71:0] VEC [11] = '{
    {16'd10, 16'd5,  4'd0, 16'd3,  16'd3,  4'h0},
    {16'd10, 16'd5,  4'd0, 16'd5,  16'd5,  4'h1},
    {16'd10, 16'd5,  4'd0, 16'd10, 16'd10, 4'h5},
    {16'd10, 16'd5,  4'd0, 16'd11, 16'd0,  4'hD},
    {16'd10, 16'd12, 4'd0, 16'd13, 16'd2,  4'hC},
    {16'd7,  16'd3,  4'd1, 16'd7,  16'd3,  4'h1},
    {16'd7,  16'd3,  4'd2, 16'd11, 16'd2,  4'h0},
    {16'd3,  16'd0,  4'd0, 16'd4,  16'd0,  4'hD},
    {16'd0,  16'd0,  4'd0, 16'd2,  16'd0,  4'hD},
    {16'd15, 16'd15, 4'd3, 16'd40, 16'd5,  4'h0},
    {16'd3,  16'd2,  4'd0, 16'd6,  16'd2,  4'hD}
  };

  task automatic chk(input string tag, input logic [15:0] got, input logic [15:0] exp);
    total++;
    if (got !== exp) begin
      bad++;
      $display("FAIL %s got=%0h exp=%0h", tag, got, exp);
    end
  endtask

  // all tasks start and end at a falling edge
  task automatic wr(input logic [2:0] a, input logic [15:0] d);
    wr_en = 1'b1; wr_addr = a; wr_data = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic rd(input logic [2:0] a, output logic [15:0] v);
    rd_addr = a;
    #1 v = rd_data;
  endtask

  task automatic pulse_cap();
    cap_trig = 1'b1;
    @(negedge clk);
    cap_trig = 1'b0;
  endtask

  task automatic restart(input logic [15:0] lim);
    wr(3'd0, 16'h0);
    wr(3'd5, 16'h0);
    wr(3'd1, lim);
    wr(3'd3, 16'hF);
  endtask

  initial begin
    #(8 * 200000);
    bad++; total++;
    $display("FAIL watchdog expired");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    logic [15:0] v;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;

    // R10 reset state
    for (int a = 0; a < 6; a++) begin
      rd(3'(a), v);
      chk("R10 reset reg", v, 16'h0);
    end
    chk("R7 reset irq", {15'b0, irq}, 16'h0);

    // R1 R4 R5 R9 table
    for (int i = 0; i < 11; i++) begin
      logic [71:0] e;
      e = VEC[i];
      restart(e[71:56]);
      wr(3'd2, e[55:40]);
      wr(3'd0, 16'h0001 | {8'h0, e[39:36], 4'h0});
      repeat (int'(e[35:20])) @(posedge clk);
      @(negedge clk);
      rd(3'd5, v);
      chk("R4 R9 count", v, e[19:4]);
      rd(3'd3, v);
      chk("R1 R4 R5 flags", v, {12'h0, e[3:0]});
    end

    // R8 debug gating
    restart(16'd1000);
    dbg_mode = 1'b1;
    wr(3'd0, 16'h0001);
    repeat (10) @(posedge clk);
    @(negedge clk);
    rd(3'd5, v);
    chk("R8 frozen in debug", v, 16'd0);
    dbg_mode = 1'b0;
    repeat (4) @(posedge clk);
    @(negedge clk);
    rd(3'd5, v);
    chk("R8 runs after debug", v, 16'd4);
    dbg_mode = 1'b1;
    wr(3'd0, 16'h0101);
    repeat (3) @(posedge clk);
    @(negedge clk);
    rd(3'd5, v);
    chk("R8 runs with dbg_run", v, 16'd7);
    dbg_mode = 1'b0;

    // R2 R3 capture
    restart(16'd1000);
    wr(3'd4, 16'h0);
    wr(3'd0, 16'h0003);
    repeat (5) @(posedge clk);
    @(negedge clk);
    pulse_cap();
    rd(3'd2, v);
    chk("R2 captured value", v, 16'd5);
    rd(3'd3, v);
    chk("R2 capture flag", v, 16'h1);
    pulse_cap();
    rd(3'd2, v);
    chk("R3 second capture value", v, 16'd6);
    rd(3'd3, v);
    chk("R3 overrun flag", v, 16'h3);

    // R6 clear semantics
    wr(3'd3, 16'h0);
    rd(3'd3, v);
    chk("R6 write zero ignored", v, 16'h3);
    wr(3'd3, 16'h2);
    rd(3'd3, v);
    chk("R6 write one clears", v, 16'h1);
    wr_en = 1'b1; wr_addr = 3'd3; wr_data = 16'h1; cap_trig = 1'b1;
    @(negedge clk);
    wr_en = 1'b0; cap_trig = 1'b0;
    rd(3'd3, v);
    chk("R6 set beats clear", v, 16'h3);

    // R7 interrupt enables
    chk("R7 no enable", {15'b0, irq}, 16'h0);
    wr(3'd4, 16'h4);
    chk("R7 other flag enabled", {15'b0, irq}, 16'h0);
    wr(3'd4, 16'h2);
    chk("R7 matching enable", {15'b0, irq}, 16'h1);
    wr(3'd3, 16'hF);
    chk("R7 cleared flags", {15'b0, irq}, 16'h0);
    rd(3'd3, v);
    chk("R6 all cleared", v, 16'h0);

    // R10 count load wins over a step
    wr(3'd5, 16'd900);
    rd(3'd5, v);
    chk("R10 count load", v, 16'd900);

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule